// File: doc/BRIEF.md
# Reconfigurable Add-Compare-Select Array

This block is the recursion core of a Viterbi decoder that can switch, step by step, between a 16-state trellis (constraint length 5) and a 64-state trellis (constraint length 7), each at code rate 1/2 or 1/3. It holds every path metric in registers. On each accepted trellis step, all 64 nodes work at once. Each node adds a branch metric to the metrics of its two predecessor states, keeps the smaller sum, and reports which predecessor won as a single survivor bit. A separate unit supplies the branch metrics, indexed by code word. Another unit stores the survivor bits and traces back through them. Both are outside this block.

The metrics are 14 bits wide, which covers short packets, so the block has no normalization logic. A start pulse opens each packet by loading the zero-tail starting metrics. The trellis shape is chosen from a 2-bit configuration input, which is sampled on every step.

Top module: `acs_array`

## Requirements
- R1: After reset, and in the cycle after `start`, state 0 holds metric 0, every other state holds 8192 (2^(PMW-1)), all survivor bits are 0 and `surv_valid` is low.
- R2: `cfg` selects the trellis per step: bit 1 high means constraint length 7 (64 states), low means 5 (16 states); bit 0 high means rate 1/3, low means rate 1/2.
- R3: State numbering: from state p with input bit u, the next state is (u << (K-2)) | (p >> 1), and the encoder register is (u << (K-1)) | p. Each code bit is the parity of that register ANDed with a generator, where the generator's top bit taps u. The generators are octal 23, 33, 25 for K=5 and octal 133, 171, 165 for K=7. The code word index is {c0,c1} at rate 1/2 and {c0,c1,c2} at rate 1/3, with c0 as the most significant bit. Word i is read from `bm_vec[i*BMW +: BMW]`.
- R4: On a step, each active state takes the smaller of the two sums (predecessor metric + branch metric), computed modulo 2^14.
- R5: When the two sums are equal, the even (lower-numbered) predecessor wins and the survivor bit is 0.
- R6: A survivor bit is 1 exactly when the odd predecessor won. New metrics and survivor bits appear one cycle after `bm_valid`. `surv_valid` pulses high for that cycle, and the survivor bits then hold until the next step.
- R7: In K=5 mode, states 16 to 63 keep their metrics and output survivor bits of 0.
- R8: With `bm_valid` and `start` both low, all metrics hold and `surv_valid` is low.
- R9: If `start` and `bm_valid` are high in the same cycle, the start wins: the metrics are initialised as in R1 and the step is dropped.
- R10: A change of `cfg` between steps takes effect on the next step and works on the current metrics, without any re-initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the starting metrics for a new packet |
| cfg | input | 2 | Trellis selection: {long constraint, rate 1/3} |
| bm_valid | input | 1 | Branch metrics are valid; perform one trellis step |
| bm_vec | input | 48 | Eight branch metrics of BMW bits, indexed by code word |
| pm_vec | output | 896 | Path metric of state n at bits [n*14 +: 14] |
| surv | output | 64 | Survivor bit per state (1 = odd predecessor won) |
| surv_valid | output | 1 | Survivor bits and metrics from a step are new this cycle |

## Verification
Two functions can land in the same cycle: a packet start and a trellis step. The bench provokes this by raising `start` and `bm_valid` together, both in the vector table and in a directed test. The result is judged correct when the metrics show the initial pattern, `surv_valid` stays low and every survivor bit is 0, meaning the step was dropped. A second collision occurs in K=5 mode, where the upper 48 states must hold their metrics through a step while the lower 16 states update. The bench judges this by comparing the upper metrics against their values from before the step.

// File: rtl/acs_pkg.sv
package acs_pkg;

   typedef enum logic [1:0] {
      CFG_K5_R2 = 2'b00,
      CFG_K5_R3 = 2'b01,
      CFG_K7_R2 = 2'b10,
      CFG_K7_R3 = 2'b11
   } acs_cfg_e;

   // Code word of one branch: parity of the encoder register against each tap set.
   function automatic logic [2:0] branch_word(input logic [15:0] enc,
                                              input logic [15:0] tap0,
                                              input logic [15:0] tap1,
                                              input logic [15:0] tap2,
                                              input logic        three);
      logic b0, b1, b2;
      b0 = ^(enc & tap0);
      b1 = ^(enc & tap1);
      b2 = ^(enc & tap2);
      return three ? {b0, b1, b2} : {1'b0, b0, b1};
   endfunction

endpackage

// File: rtl/acs_node.sv
module acs_node #(
   parameter int          PMW      = 14,
   parameter int          BMW      = 6,
   parameter logic [13:0] INIT_VAL = 14'd0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           init,
   input  logic           step,
   input  logic           active,
   input  logic [PMW-1:0] pm_even,
   input  logic [PMW-1:0] pm_odd,
   input  logic [BMW-1:0] bm_even,
   input  logic [BMW-1:0] bm_odd,
   output logic [PMW-1:0] pm_q,
   output logic           surv_q
);
   logic [PMW-1:0] sum_even, sum_odd;
   logic           odd_wins;

   assign sum_even = pm_even + PMW'(bm_even);
   assign sum_odd  = pm_odd  + PMW'(bm_odd);
   assign odd_wins = sum_odd < sum_even;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_q   <= PMW'(INIT_VAL);
         surv_q <= 1'b0;
      end else if (init) begin
         pm_q   <= PMW'(INIT_VAL);
         surv_q <= 1'b0;
      end else if (step) begin
         if (active) pm_q <= odd_wins ? sum_odd : sum_even;
         surv_q <= active & odd_wins;
      end
   end

   // R7: an inactive node keeps its metric and reports no survivor
   a_r7_idle_node_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !init && !active) |=> ($stable(pm_q) && !surv_q));

   // R5: equal sums resolve to the even predecessor
   a_r5_tie_even : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !init && active && (sum_even == sum_odd)) |=> (!surv_q && pm_q == $past(sum_even)));

   // R4: the kept metric is never above either candidate
   a_r4_min_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !init && active) |=> (pm_q <= $past(sum_even) && pm_q <= $past(sum_odd)));

endmodule

// File: rtl/acs_array.sv
module acs_array #(
   parameter int          KSHORT = 5,
   parameter int          KLONG  = 7,
   parameter int          PMW    = 14,
   parameter int          BMW    = 6,
   parameter logic [15:0] GS0    = 16'o23,
   parameter logic [15:0] GS1    = 16'o33,
   parameter logic [15:0] GS2    = 16'o25,
   parameter logic [15:0] GL0    = 16'o133,
   parameter logic [15:0] GL1    = 16'o171,
   parameter logic [15:0] GL2    = 16'o165
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [1:0]                 cfg,
   input  logic                       bm_valid,
   input  logic [8*BMW-1:0]           bm_vec,
   output logic [(1<<(KLONG-1))*PMW-1:0] pm_vec,
   output logic [(1<<(KLONG-1))-1:0]  surv,
   output logic                       surv_valid
);
   import acs_pkg::*;

   localparam int NST     = 1 << (KLONG - 1);
   localparam int NSS     = 1 << (KSHORT - 1);
   localparam int NCW     = 8;
   localparam int INIT_PM = 1 << (PMW - 1);

   if (KSHORT >= KLONG)  begin : g_bad_k   $error("KSHORT must be below KLONG"); end
   if (KLONG > 16)       begin : g_bad_kl  $error("KLONG too large for tap width"); end
   if (PMW != 14)        begin : g_bad_pmw $error("metric width fixed at 14 bits"); end
   if (BMW + 2 > PMW)    begin : g_bad_bmw $error("BMW too wide for metrics"); end

   logic [PMW-1:0] pm_q [NST];
   logic           step;
   logic           long_k, rate3;

   assign step   = bm_valid & ~start;
   assign long_k = cfg[1];
   assign rate3  = cfg[0];

   for (genvar n = 0; n < NST; n++) begin : g_node
      localparam int          PEL = (n * 2) % NST;
      localparam int          UL  = n / (NST / 2);
      localparam bit          SOK = (n < NSS);
      localparam int          PES = SOK ? (n * 2) % NSS : 0;
      localparam int          US  = SOK ? n / (NSS / 2) : 0;
      localparam logic [15:0] EL  = 16'(UL * NST + PEL);
      localparam logic [15:0] ES  = 16'(US * NSS + PES);
      localparam logic [13:0] IV  = (n == 0) ? 14'd0 : 14'(INIT_PM);

      logic [PMW-1:0] pm_e, pm_o;
      logic [2:0]     cw_e, cw_o;
      logic [BMW-1:0] bm_e, bm_o;
      logic           active;

      always_comb begin
         if (long_k) begin
            pm_e = pm_q[PEL];
            pm_o = pm_q[PEL + 1];
            cw_e = branch_word(EL,         GL0, GL1, GL2, rate3);
            cw_o = branch_word(EL | 16'd1, GL0, GL1, GL2, rate3);
         end else begin
            pm_e = pm_q[PES];
            pm_o = pm_q[PES + 1];
            cw_e = branch_word(ES,         GS0, GS1, GS2, rate3);
            cw_o = branch_word(ES | 16'd1, GS0, GS1, GS2, rate3);
         end
      end

      assign bm_e   = bm_vec[cw_e*BMW +: BMW];
      assign bm_o   = bm_vec[cw_o*BMW +: BMW];
      assign active = long_k | SOK;

      acs_node #(.PMW(PMW), .BMW(BMW), .INIT_VAL(IV)) u_node (
         .clk     (clk),
         .rst_n   (rst_n),
         .init    (start),
         .step    (step),
         .active  (active),
         .pm_even (pm_e),
         .pm_odd  (pm_o),
         .bm_even (bm_e),
         .bm_odd  (bm_o),
         .pm_q    (pm_q[n]),
         .surv_q  (surv[n])
      );

      assign pm_vec[n*PMW +: PMW] = pm_q[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) surv_valid <= 1'b0;
      else        surv_valid <= step;
   end

   // R1: a start leaves state 0 at zero and no survivors flagged
   a_r1_start_zero : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (pm_vec[PMW-1:0] == '0 && !surv_valid && surv == '0));

   // R8: no step, no start: metrics frozen
   a_r8_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!bm_valid && !start) |=> ($stable(pm_vec) && !surv_valid));

   // R9: start and a step together: step dropped
   a_r9_start_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (start && bm_valid) |=> !surv_valid);

   // R6: survivors flagged only after an accepted step
   a_r6_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      surv_valid |-> $past(bm_valid && !start));

endmodule

// File: tb/acs_array_bench.sv
module acs_array_bench;
   localparam int PMW = 14;
   localparam int BMW = 6;
   localparam int NST = 64;
   localparam int NV  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        cfg = 2'b00;
   logic              bm_valid = 1'b0;
   logic [8*BMW-1:0]  bm_vec = '0;
   logic [NST*PMW-1:0] pm_vec;
   logic [NST-1:0]    surv;
   logic              surv_valid;

   acs_array u_acs_array (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .bm_valid(bm_valid),
      .bm_vec(bm_vec), .pm_vec(pm_vec), .surv(surv), .surv_valid(surv_valid)
   );

   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [PMW-1:0] m_pm [NST];
   logic           m_sv [NST];
   logic           m_valid;

   // {start, valid, cfg, bm[47:0]}; tags exercised: R2 R3 R4 R10 R7 R9
   localparam logic [51:0] TBL [NV] = '{
      {1'b1, 1'b0, 2'b11, 48'h0},
      {1'b0, 1'b1, 2'b11, 48'h0C3_1850_A2E7},
      {1'b0, 1'b1, 2'b11, 48'h1A2_0B44_3C91},
      {1'b0, 1'b1, 2'b11, 48'h055_2D13_0F6A},
      {1'b0, 1'b0, 2'b11, 48'hFFF_FFFF_FFFF},
      {1'b0, 1'b1, 2'b10, 48'h000_0000_2D8C},
      {1'b0, 1'b1, 2'b10, 48'h000_0000_14C7},
      {1'b0, 1'b1, 2'b00, 48'h000_0000_3A51},
      {1'b0, 1'b1, 2'b00, 48'h000_0000_0C9E},
      {1'b0, 1'b1, 2'b01, 48'h2B1_7403_95D2},
      {1'b1, 1'b1, 2'b11, 48'h123_4567_89AB},
      {1'b0, 1'b1, 2'b11, 48'h3C0_F00F_C30C}
   };

   function automatic logic par(input logic [15:0] x);
      logic p = 1'b0;
      for (int i = 0; i < 16; i++) p ^= x[i];
      return p;
   endfunction

   task automatic model_tick(input logic st, input logic v, input logic [1:0] c,
                             input logic [8*BMW-1:0] bm);
      if (st) begin
         for (int s = 0; s < NST; s++) begin
            m_pm[s] = (s == 0) ? '0 : 14'd8192;
            m_sv[s] = 1'b0;
         end
         m_valid = 1'b0;
      end else if (v) begin
         int m;
         logic [PMW-1:0] nx [NST];
         logic           nsv [NST];
         bit             seen [NST];
         logic [15:0]    g0, g1, g2;
         m = c[1] ? 6 : 4;
         g0 = c[1] ? 16'o133 : 16'o23;
         g1 = c[1] ? 16'o171 : 16'o33;
         g2 = c[1] ? 16'o165 : 16'o25;
         for (int s = 0; s < NST; s++) begin
            nx[s] = m_pm[s]; nsv[s] = 1'b0; seen[s] = 1'b0;
         end
         for (int p = 0; p < (1 << m); p++) begin
            for (int u = 0; u < 2; u++) begin
               int ns;
               int w;
               logic [15:0] r;
               logic [PMW-1:0] cand;
               ns = (u << (m - 1)) | (p >> 1);
               r  = 16'((u << m) | p);
               if (c[0]) w = {par(r & g0), par(r & g1), par(r & g2)};
               else      w = {par(r & g0), par(r & g1)};
               cand = m_pm[p] + PMW'(bm[w*BMW +: BMW]);
               if (!seen[ns] || cand < nx[ns]) begin
                  nx[ns] = cand; nsv[ns] = p[0]; seen[ns] = 1'b1;
               end
            end
         end
         for (int s = 0; s < NST; s++) begin
            m_pm[s] = nx[s]; m_sv[s] = nsv[s];
         end
         m_valid = 1'b1;
      end else begin
         m_valid = 1'b0;
      end
   endtask

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic compare_model(input string req);
      int bad_pm = -1;
      int bad_sv = -1;
      for (int s = NST - 1; s >= 0; s--) begin
         if (pm_vec[s*PMW +: PMW] != m_pm[s]) bad_pm = s;
         if (surv[s] != m_sv[s]) bad_sv = s;
      end
      if (bad_pm >= 0)
         check(1'b0, {req, " metric"}, pm_vec[bad_pm*PMW +: PMW], m_pm[bad_pm]);
      else check(1'b1, req, 0, 0);
      if (bad_sv >= 0) check(1'b0, {req, " survivor"}, surv[bad_sv], m_sv[bad_sv]);
      else check(1'b1, req, 0, 0);
      check(surv_valid == m_valid, {req, " surv_valid"}, surv_valid, m_valid);
   endtask

   // Driven at a falling edge; returns at the next falling edge with outputs settled.
   task automatic apply(input logic st, input logic v, input logic [1:0] c,
                        input logic [8*BMW-1:0] bm);
      start = st; bm_valid = v; cfg = c; bm_vec = bm;
      @(posedge clk);
      model_tick(st, v, c, bm);
      #1;
      start = 1'b0; bm_valid = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [8*BMW-1:0] fill(input int v);
      logic [8*BMW-1:0] r;
      for (int i = 0; i < 8; i++) r[i*BMW +: BMW] = BMW'(v);
      return r;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [PMW-1:0] upper [NST];
      logic [8*BMW-1:0] bm;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(pm_vec[PMW-1:0] == 0, "R1 state0", pm_vec[PMW-1:0], 0);
      check(pm_vec[37*PMW +: PMW] == 14'd8192, "R1 other", pm_vec[37*PMW +: PMW], 8192);
      check(surv == '0 && !surv_valid, "R1 survivors", surv, 0);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         apply(TBL[i][51], TBL[i][50], TBL[i][49:48], TBL[i][47:0]);
         compare_model($sformatf("R4 R10 vector %0d", i));
      end

      // R6: odd predecessor wins at state 1 (preds 2 -> word 3, 3 -> word 0)
      apply(1'b1, 1'b0, 2'b00, '0);
      bm = fill(20);
      bm[3*BMW +: BMW] = 6'd10;
      bm[0 +: BMW] = 6'd0;
      apply(1'b0, 1'b1, 2'b00, bm);
      check(surv[1] == 1'b1, "R6 odd winner", surv[1], 1);
      check(pm_vec[1*PMW +: PMW] == 14'd8192, "R6 odd metric", pm_vec[1*PMW +: PMW], 8192);
      check(surv[0] == 1'b0 && pm_vec[PMW-1:0] == 0, "R6 even winner", surv[0], 0);
      check(surv_valid, "R6 surv_valid pulse", surv_valid, 1);
      apply(1'b0, 1'b0, 2'b00, '0);
      check(!surv_valid && surv[1], "R6 survivors hold", {surv_valid, surv[1]}, 1);

      // R5: tie on equal sums
      apply(1'b1, 1'b0, 2'b00, '0);
      apply(1'b0, 1'b1, 2'b00, fill(5));
      check(surv[1] == 1'b0, "R5 tie survivor", surv[1], 0);
      check(pm_vec[1*PMW +: PMW] == 14'd8197, "R5 tie metric", pm_vec[1*PMW +: PMW], 8197);

      // R7: K=5 step leaves upper states unchanged
      apply(1'b0, 1'b1, 2'b11, 48'h2A5_1C3E_0B77);
      for (int s = 0; s < NST; s++) upper[s] = pm_vec[s*PMW +: PMW];
      apply(1'b0, 1'b1, 2'b01, 48'h0F1_2233_4455);
      begin
         int diff = 0;
         for (int s = 16; s < NST; s++) if (pm_vec[s*PMW +: PMW] != upper[s]) diff++;
         check(diff == 0, "R7 upper metrics hold", diff, 0);
      end
      check(surv[63:16] == '0, "R7 upper survivors", surv[63:16], 0);
      compare_model("R7 lower update");

      // R8: idle cycle
      for (int s = 0; s < NST; s++) upper[s] = pm_vec[s*PMW +: PMW];
      apply(1'b0, 1'b0, 2'b10, fill(63));
      begin
         int diff = 0;
         for (int s = 0; s < NST; s++) if (pm_vec[s*PMW +: PMW] != upper[s]) diff++;
         check(diff == 0 && !surv_valid, "R8 idle hold", diff, 0);
      end

      // R9: start and step together
      apply(1'b1, 1'b1, 2'b10, fill(7));
      check(pm_vec[PMW-1:0] == 0 && pm_vec[63*PMW +: PMW] == 14'd8192, "R9 init wins",
            pm_vec[63*PMW +: PMW], 8192);
      check(!surv_valid && surv == '0, "R9 step dropped", surv_valid, 0);

      finish_run();
   end

endmodule